// File: doc/BRIEF.md
# Sampled Oscillator Parity Mixer with Skew Cancellation

This block turns a set of free-running, unsynchronised oscillator lines into one random bit per system clock. Each edge captures every oscillator line into its own flip-flop. The captured samples are then reduced to a single bit by an XOR tree. Only registered values reach the XOR, so a runt pulse between two lines that change close together cannot skew the sum.

The reduced bit is XORed with two terms supplied by the serial consumer that reads the stream:

- the least significant bit of its current bit position;
- a level that flips once per transmitted byte.

Together these terms invert the stream with the pattern 0x55 on one byte and 0xAA on the next. This spreads any excess of ones or zeros evenly over both values.

The held output is also fed back into the XOR. Each new sample therefore decides whether the held bit is kept or inverted, rather than replacing it. The final bit is registered once more before it leaves the block, so any metastable capture has a full cycle to settle.

Top module: `rng_xor_combiner`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every sample flip-flop and `rnd_o` are cleared. After that edge, `rnd_o` reads 0.
- R2: All `osc_i` lines are sampled at the same rising edge. An oscillator value present at edge k first influences `rnd_o` after edge k+1, which is two edges of latency. It does not influence `rnd_o` after edge k.
- R3: After each edge E, `rnd_o` becomes the XOR of four terms: the `rnd_o` value held before E, the XOR of all oscillator samples captured at edge E-1, `bit_lsb_i` at E, and `byte_flip_i` at E.
- R4: When the other terms are zero, `bit_lsb_i` = 1 at an edge inverts `rnd_o`. This term has one edge of latency.
- R5: When the other terms are zero, `byte_flip_i` = 1 at an edge inverts `rnd_o`. This term has one edge of latency.
- R6: When the sampled oscillator parity is 0 and both consumer terms are 0, `rnd_o` holds its value. This includes an even number of oscillator lines at 1.
- R7: An oscillator pulse that begins and ends between two rising edges has no effect on `rnd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_i | input | NUM_OSC | Asynchronous oscillator lines |
| bit_lsb_i | input | 1 | LSB of the consumer's current bit index |
| byte_flip_i | input | 1 | Consumer level that flips after each byte |
| rnd_o | output | 1 | Registered random bit |

## Verification
The bench builds the block with the default of nine oscillator lines. With nine lines, inverting every line flips the parity, while a selected even subset leaves it unchanged. This brings both the hold case (R6) and the inverting case (R3) within reach from chosen input words. Random oscillator words mixed with all four combinations of the consumer terms exercise the full update rule. Directed pulses placed between edges show that only sampled values count (R7).

// File: rtl/rng_mix_pkg.sv
// Shared types for the oscillator parity mixer.
// Assumes: consumer terms are synchronous to the sampling clock.
package rng_mix_pkg;
    localparam int DEFAULT_OSC = 9;

    // Bias-cancelling terms delivered by the serial consumer.
    typedef struct packed {
        logic bit_lsb;
        logic byte_flip;
    } debias_t;
endpackage

// File: rtl/osc_capture.sv
// Captures every oscillator line into its own flip-flop on one common edge.
// Assumes: lines are asynchronous; downstream logic only sees registered values.
module osc_capture #(
    parameter int NUM_OSC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_i,
    output logic [NUM_OSC-1:0] samp_o
);
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_cap
        // Sample one oscillator line per clock; clear under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) samp_o[g] <= 1'b0;
            else        samp_o[g] <= osc_i[g];
        end
    end
endmodule

// File: rtl/parity_tree.sv
// Balanced XOR reduction of registered samples, padded to a power of two.
// Assumes: inputs are registered, so no glitch reaches a storage element.
module parity_tree #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             par_o
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < WIDTH) begin : g_used
            assign node[LEAVES - 1 + l] = bits_i[l];
        end else begin : g_pad
            assign node[LEAVES - 1 + l] = 1'b0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_inner
        assign node[n] = node[2*n + 1] ^ node[2*n + 2];
    end

    assign par_o = node[0];
endmodule

// File: rtl/debias_feedback.sv
// Output register: folds parity and consumer terms into the held bit.
// Assumes: consumer terms change only on bit and byte boundaries.
module debias_feedback
    import rng_mix_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    par_i,
    input  debias_t terms_i,
    output logic    bit_o
);
    logic invert;

    // Decide whether the held bit is inverted this cycle.
    always_comb invert = par_i ^ terms_i.bit_lsb ^ terms_i.byte_flip;

    // Keep or invert the held random bit; clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_o <= 1'b0;
        else        bit_o <= bit_o ^ invert;
    end
endmodule

// File: rtl/rng_xor_combiner.sv
// Top: sample oscillators, reduce by XOR, debias with feedback, register.
// Assumes: osc_i asynchronous; bit_lsb_i and byte_flip_i synchronous to clk.
module rng_xor_combiner
    import rng_mix_pkg::*;
#(
    parameter int NUM_OSC = DEFAULT_OSC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic               bit_lsb_i,
    input  logic               byte_flip_i,
    output logic               rnd_o
);
    logic [NUM_OSC-1:0] samp;
    logic               par;
    debias_t            terms;

    // Bundle consumer terms.
    always_comb begin
        terms.bit_lsb   = bit_lsb_i;
        terms.byte_flip = byte_flip_i;
    end

    osc_capture #(.NUM_OSC(NUM_OSC)) u_cap (
        .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .samp_o(samp)
    );

    parity_tree #(.WIDTH(NUM_OSC)) u_tree (
        .bits_i(samp), .par_o(par)
    );

    debias_feedback u_fb (
        .clk(clk), .rst_n(rst_n), .par_i(par), .terms_i(terms), .bit_o(rnd_o)
    );
endmodule

// File: rtl/rng_xor_combiner_chk.sv
// Port-level checker for the parity mixer, bound to every instance.
// Assumes: synchronous active-low reset.
module rng_xor_combiner_chk #(
    parameter int NUM_OSC = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OSC-1:0] osc_i,
    input logic               bit_lsb_i,
    input logic               byte_flip_i,
    input logic               rnd_o
);
    logic [1:0] live;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= 2'd0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (rnd_o == 1'b0));

    // R3
    update_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd2) |-> (rnd_o == ($past(rnd_o) ^ (^$past(osc_i, 2))
                                      ^ $past(bit_lsb_i) ^ $past(byte_flip_i))));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((live >= 2'd2) && !(^$past(osc_i, 2)) && !$past(bit_lsb_i) && !$past(byte_flip_i))
        |-> (rnd_o == $past(rnd_o)));

    // R4
    lsb_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((live >= 2'd2) && !(^$past(osc_i, 2)) && $past(bit_lsb_i) && !$past(byte_flip_i))
        |-> (rnd_o != $past(rnd_o)));

    // R5
    flip_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((live >= 2'd2) && !(^$past(osc_i, 2)) && !$past(bit_lsb_i) && $past(byte_flip_i))
        |-> (rnd_o != $past(rnd_o)));
endmodule

bind rng_xor_combiner rng_xor_combiner_chk #(.NUM_OSC(NUM_OSC)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .bit_lsb_i(bit_lsb_i),
    .byte_flip_i(byte_flip_i), .rnd_o(rnd_o)
);

// File: tb/rng_xor_combiner_bench.sv
module rng_xor_combiner_bench;
    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] osc = '0;
    logic         lsb = 1'b0;
    logic         flip = 1'b0;
    logic         rnd;

    int checks = 0;
    int fails  = 0;
    bit exp_out = 1'b0;
    bit exp_par = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rng_xor_combiner #(.NUM_OSC(N)) u_rng_xor_combiner (
        .clk(clk), .rst_n(rst_n), .osc_i(osc), .bit_lsb_i(lsb),
        .byte_flip_i(flip), .rnd_o(rnd)
    );

    function automatic bit parity(input logic [N-1:0] v);
        bit p = 1'b0;
        for (int i = 0; i < N; i++) p ^= v[i];
        return p;
    endfunction

    function automatic bit next_out(input bit cur, input bit par, input bit l, input bit f);
        return cur ^ par ^ l ^ f;
    endfunction

    task automatic check(input string req, input bit expv);
        checks++;
        if (rnd !== expv) begin
            fails++;
            $display("FAIL %s: rnd_o=%b expected=%b", req, rnd, expv);
        end
    endtask

    // Drive inputs at the falling edge, advance one rising edge, check at the next falling edge.
    task automatic step(input string req, input logic [N-1:0] o, input bit l, input bit f,
                        input bit glitch);
        osc = o; lsb = l; flip = f;
        if (glitch) begin
            #1 osc = ~o;
            #0.5 osc = o;
        end
        @(posedge clk);
        if (!rst_n) begin
            exp_out = 1'b0; exp_par = 1'b0;
        end else begin
            exp_out = next_out(exp_out, exp_par, l, f);
            exp_par = parity(o);
        end
        @(negedge clk);
        check(req, exp_out);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R1: outputs stay cleared while reset holds, whatever the inputs.
        for (int i = 0; i < 4; i++) step("R1", N'($urandom), 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        // R2: an odd-parity word shows after two edges, not after one.
        step("R2", 9'b000000001, 1'b0, 1'b0, 1'b0);
        check("R2 one edge", 1'b0);
        step("R2", 9'b000000000, 1'b0, 1'b0, 1'b0);
        check("R2 two edges", 1'b1);
        // R6: even number of lines high keeps the held bit.
        for (int i = 0; i < 4; i++) step("R6", 9'b110000011, 1'b0, 1'b0, 1'b0);
        // R3: all nine lines high is odd parity and inverts.
        step("R3", 9'h1FF, 1'b0, 1'b0, 1'b0);
        step("R3", 9'h000, 1'b0, 1'b0, 1'b0);
        // R4: bit LSB alone inverts one edge later.
        step("R4", 9'h000, 1'b1, 1'b0, 1'b0);
        step("R4", 9'h000, 1'b1, 1'b0, 1'b0);
        // R5: byte flip alone inverts one edge later.
        step("R5", 9'h000, 1'b0, 1'b1, 1'b0);
        step("R5", 9'h000, 1'b0, 1'b0, 1'b0);
        // R7: pulses between edges are ignored.
        for (int i = 0; i < 6; i++) step("R7", 9'h000, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) step("R7", N'($urandom), 1'b0, 1'b0, 1'b1);
        // R3: random words across a run of bytes with the consumer pattern.
        for (int b = 0; b < 40; b++)
            for (int k = 0; k < 8; k++)
                step("R3", N'($urandom), k[0], b[0], 1'b0);
        // R1: reset mid-stream clears again.
        rst_n = 1'b0;
        step("R1", 9'h1FF, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step("R1", 9'h000, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule